// File: doc/BRIEF.md
# Iterative Logarithmic Multiplier

This block multiplies two unsigned integers with a logarithmic method instead of partial-product arrays. Each operand is split into a power of two at its leading-one position plus a residual, which is the operand with that bit cleared. The first pass adds a shift-and-add approximation of the product to a running sum. Each later pass treats the product of the two residuals, which the first approximation leaves out, as a new multiplication and repeats the same step on it.

A caller sets the number of correction passes on each request, so it can accept an approximate product with short latency or ask for the exact product. The unit runs one pass per clock. It stops early as soon as either residual becomes zero, because at that point the running sum is already exact.

A request is a one-cycle `start` pulse with the operands and the pass count. The result appears on `product` when `done` pulses and stays there until the next accepted request.

Top module: `ilm_mult`

## Requirements
- R1: After reset, `done` is 0 and `product` is 0.
- R2: If either operand is 0 when a request is accepted, `product` becomes 0 and `done` pulses on the first cycle after the start cycle.
- R3: With a pass count of 0, the result is the basic approximation 2^(ka+kb) + ra·2^kb + rb·2^ka. Here ka and kb are the leading-one positions and ra and rb are the residuals. For example, 3×3 gives 8 and 15×15 gives 176.
- R4: Each correction pass adds the basic approximation of the current residual pair, and the next pass works on the new residuals. For 15×15, counts 1, 2 and 3 give 216, 224 and 225.
- R5: Passes stop as soon as either residual is zero, and the result is then exact. 8×13 with a count of 10 gives 104 after a single pass.
- R6: With a pass count of at least WIDTH, the result equals the exact product for any operands.
- R7: The result never exceeds the exact product and never decreases when the pass count grows.
- R8: `done` is high for exactly one cycle per request. `product` holds its value while the unit is idle and no request arrives.
- R9: A `start` pulse that arrives while a multiplication is running is ignored. It changes neither the result nor the latency.
- R10: For a nonzero request that runs P passes, `done` rises P+1 cycles after the start cycle. P is the smaller of count+1 and the number of passes up to the first zero residual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only when idle |
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| iters | input | ITER_W | Number of correction passes after the basic approximation |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*WIDTH | Accumulated product, registered |

## Verification
The assertions check on every cycle that:
- the running sum never decreases during a multiplication;
- each pass term stays at or below the exact product of its inputs;
- the detected leading one leaves a residual with no higher bits set;
- no pass runs on a zero operand;
- `done` is a single-cycle pulse and a zero operand gives an immediate zero result;
- `product` stays stable while the unit is idle.

Only the bench scenarios can show the rest:
- the specific approximation values for given pass counts;
- the exact product once the count reaches the operand width;
- growth of the result from one pass count to the next;
- the cycle count to `done`;
- that a start pulse during a running multiplication is ignored.

// File: rtl/ilm_pkg.sv
package ilm_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} ilm_state_t;
endpackage

// File: rtl/ilm_lod.sv
module ilm_lod #(
  parameter int WIDTH = 16,
  localparam int PW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] val,
  output logic [PW-1:0]    pos,
  output logic [WIDTH-1:0] resid
);
  always_comb begin
    pos = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (val[i]) pos = PW'(i);
    end
    resid = val & ~({{(WIDTH-1){1'b0}}, 1'b1} << pos);
  end

  // the residual must hold no bit at or above the leading one (R4)
  always_comb begin
    if (val != '0) begin
      assert_resid_below_lead_R4: assert ((resid >> pos) == '0);
    end
  end
endmodule

// File: rtl/ilm_pass.sv
module ilm_pass #(
  parameter int WIDTH = 16,
  localparam int PW  = $clog2(WIDTH),
  localparam int PW2 = 2 * WIDTH
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [PW2-1:0]   term,
  output logic [WIDTH-1:0] res_a,
  output logic [WIDTH-1:0] res_b
);
  logic [WIDTH-1:0] opnd [2];
  logic [PW-1:0]    lead [2];
  logic [WIDTH-1:0] rsd  [2];

  assign opnd[0] = a;
  assign opnd[1] = b;

  for (genvar g = 0; g < 2; g++) begin : g_lod
    ilm_lod #(.WIDTH(WIDTH)) u_lod (
      .val   (opnd[g]),
      .pos   (lead[g]),
      .resid (rsd[g])
    );
  end

  logic [PW:0]    ksum;
  logic [PW2-1:0] pow_term, cross_a, cross_b;

  always_comb begin
    ksum     = {1'b0, lead[0]} + {1'b0, lead[1]};
    pow_term = {{(PW2-1){1'b0}}, 1'b1} << ksum;
    cross_a  = {{WIDTH{1'b0}}, rsd[0]} << lead[1];
    cross_b  = {{WIDTH{1'b0}}, rsd[1]} << lead[0];
    term     = pow_term + cross_a + cross_b;
  end

  assign res_a = rsd[0];
  assign res_b = rsd[1];

  // a single pass never overshoots the exact product of its inputs (R7)
  always_comb begin
    if (a != '0 && b != '0) begin
      assert_term_le_exact_R7: assert (term <= ({{WIDTH{1'b0}}, a} * {{WIDTH{1'b0}}, b}));
    end
  end
endmodule

// File: rtl/ilm_mult.sv
module ilm_mult
  import ilm_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int ITER_W = 5,
  localparam int PW2 = 2 * WIDTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WIDTH-1:0]  op_a,
  input  logic [WIDTH-1:0]  op_b,
  input  logic [ITER_W-1:0] iters,
  output logic              done,
  output logic [PW2-1:0]    product
);
  ilm_state_t        st;
  logic [WIDTH-1:0]  opa_q, opb_q;
  logic [ITER_W-1:0] cnt;
  logic [PW2-1:0]    acc;
  logic              done_q;
  logic [PW2-1:0]    term;
  logic [WIDTH-1:0]  res_a, res_b;
  logic              finish;

  ilm_pass #(.WIDTH(WIDTH)) u_pass (
    .a     (opa_q),
    .b     (opb_q),
    .term  (term),
    .res_a (res_a),
    .res_b (res_b)
  );

  assign finish = (res_a == '0) || (res_b == '0) || (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      opa_q  <= '0;
      opb_q  <= '0;
      cnt    <= '0;
      acc    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            acc   <= '0;
            opa_q <= op_a;
            opb_q <= op_b;
            cnt   <= iters;
            if (op_a == '0 || op_b == '0) done_q <= 1'b1;
            else                          st     <= ST_RUN;
          end
        end
        ST_RUN: begin
          acc   <= acc + term;
          opa_q <= res_a;
          opb_q <= res_b;
          if (finish) begin
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign done    = done_q;
  assign product = acc;

  assert_zero_result_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && start && (op_a == '0 || op_b == '0)) |=> (done && product == '0));

  assert_run_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN) |-> (opa_q != '0 && opb_q != '0));

  assert_acc_monotone_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN) |=> (acc >= $past(acc)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !start) |=> $stable(product));
endmodule

// File: tb/tb_ilm_mult.sv
module tb_ilm_mult;
  localparam int WIDTH  = 16;
  localparam int ITER_W = 5;
  localparam int PW2    = 2 * WIDTH;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [WIDTH-1:0]  op_a = '0, op_b = '0;
  logic [ITER_W-1:0] iters = '0;
  logic              done;
  logic [PW2-1:0]    product;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  ilm_mult #(.WIDTH(WIDTH), .ITER_W(ITER_W)) dut (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .iters(iters), .done(done), .product(product)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // issue a request, wait for done; lat counts cycles from start capture to done
  task automatic do_mul(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                        input int n, output logic [PW2-1:0] p, output int lat);
    @(negedge clk);
    op_a = a; op_b = b; iters = ITER_W'(n); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    p = product;
    @(negedge clk);
    check(done == 1'b0, "R8 done single pulse", done, 0);
  endtask

  task automatic t_reset();
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(product == '0, "R1 product after reset", product, 0);
  endtask

  task automatic t_zero();
    logic [PW2-1:0] p; int lat;
    do_mul(16'd0, 16'd1234, 5, p, lat);
    check(p == 0, "R2 zero a product", p, 0);
    check(lat == 1, "R2 zero a latency", lat, 1);
    do_mul(16'd777, 16'd0, 0, p, lat);
    check(p == 0, "R2 zero b product", p, 0);
    check(lat == 1, "R2 zero b latency", lat, 1);
  endtask

  task automatic t_basic();
    logic [PW2-1:0] p; int lat;
    do_mul(16'd3, 16'd3, 0, p, lat);
    check(p == 8, "R3 3x3 basic", p, 8);
    check(lat == 2, "R10 one pass latency", lat, 2);
    do_mul(16'd15, 16'd15, 0, p, lat);
    check(p == 176, "R3 15x15 basic", p, 176);
  endtask

  task automatic t_refine();
    logic [PW2-1:0] p; int lat;
    do_mul(16'd15, 16'd15, 1, p, lat);
    check(p == 216, "R4 15x15 one correction", p, 216);
    check(lat == 3, "R10 two pass latency", lat, 3);
    do_mul(16'd15, 16'd15, 2, p, lat);
    check(p == 224, "R4 15x15 two corrections", p, 224);
    do_mul(16'd15, 16'd15, 3, p, lat);
    check(p == 225, "R4 15x15 three corrections", p, 225);
    check(lat == 5, "R10 four pass latency", lat, 5);
  endtask

  task automatic t_early();
    logic [PW2-1:0] p; int lat;
    do_mul(16'd8, 16'd13, 10, p, lat);
    check(p == 104, "R5 early exact 8x13", p, 104);
    check(lat == 2, "R5 early stop latency", lat, 2);
    do_mul(16'd3, 16'd3, 9, p, lat);
    check(p == 9, "R5 3x3 stop after residual zero", p, 9);
    check(lat == 3, "R5 3x3 latency", lat, 3);
  endtask

  task automatic t_exact_sweep();
    logic [PW2-1:0] p; int lat;
    logic [15:0] lf = 16'hACE1;
    logic [WIDTH-1:0] a, b;
    do_mul(16'hFFFF, 16'hFFFF, WIDTH, p, lat);
    check(p == 32'hFFFE0001, "R6 max operands exact", p, 32'hFFFE0001);
    for (int i = 0; i < 24; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      b = lf ^ 16'h5A3C;
      do_mul(a, b, WIDTH, p, lat);
      check(p == PW2'(a) * PW2'(b), "R6 exact at full count", p, PW2'(a) * PW2'(b));
    end
  endtask

  task automatic t_monotone();
    logic [PW2-1:0] p, prev, ex; int lat;
    logic [WIDTH-1:0] av [4] = '{16'hFFFF, 16'hB6D5, 16'h0F0F, 16'h8001};
    logic [WIDTH-1:0] bv [4] = '{16'h7FFF, 16'hDB6B, 16'h00FF, 16'hFFFE};
    for (int k = 0; k < 4; k++) begin
      ex = PW2'(av[k]) * PW2'(bv[k]);
      prev = '0;
      for (int n = 0; n <= WIDTH; n++) begin
        do_mul(av[k], bv[k], n, p, lat);
        check(p <= ex, "R7 never above exact", p, ex);
        check(p >= prev, "R7 non-decreasing with count", p, prev);
        prev = p;
      end
    end
  endtask

  task automatic t_busy_start();
    int lat;
    @(negedge clk);
    op_a = 16'd15; op_b = 16'd15; iters = 5'd3; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_a = 16'd1; op_b = 16'd2; iters = 5'd0;
    lat = 1;
    @(negedge clk);
    lat++;
    start = 1'b0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check(product == 225, "R9 busy start ignored result", product, 225);
    check(lat == 5, "R9 busy start ignored latency", lat, 5);
  endtask

  task automatic t_hold();
    logic [PW2-1:0] p; int lat;
    do_mul(16'd100, 16'd200, WIDTH, p, lat);
    op_a = 16'd9; op_b = 16'd9;
    repeat (5) @(negedge clk);
    check(product == 20000, "R8 product held while idle", product, 20000);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_zero();
    t_basic();
    t_refine();
    t_early();
    t_exact_sweep();
    t_monotone();
    t_busy_start();
    t_hold();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule